// File: doc/BRIEF.md
# Pipelined Word and Byte Memory Port

This block connects a processor datapath to a synchronous memory. It has two independent paths. The data path uses a word-index address register and a 32-bit data register, and supports read and write. The instruction path uses a byte-address program counter and an 8-bit fetch buffer, and supports fetch only. The datapath loads the address register, the data register and the program counter from a shared result bus. It starts memory operations by raising per-cycle read, write and fetch strobes.

Every read or fetch takes a fixed number of cycles. A request issued in cycle k writes its result into the destination register at the clock edge that ends cycle k+1. The new value is visible from cycle k+2. Until then the destination keeps its earlier contents. One request per path is accepted every cycle, so back-to-back requests overlap. The data-path address is a word index, and the port scales it by four to form the byte address on the memory bus. The program counter already holds a byte address and goes to the fetch port unchanged.

The memory is outside the block. It samples the request at the clock edge that ends the issue cycle. It presents read data during the following cycle, and it performs writes at that same edge.

Top module: `wb_mem_port`

## Requirements
- R1: While reset is high, no memory strobe (data read, data write, fetch) is driven, whatever the request inputs are. After reset the word-address register, data register, program counter and fetch buffer all read zero.
- R2: During a data request, the memory byte address equals the word-address register value of the issuing cycle times four. Its two low bits are zero. A load of the word-address register in that same cycle affects only later requests.
- R3: A read issued in cycle k leaves the data register holding the memory word at the scaled address from cycle k+2 onward.
- R4: In cycle k+1 after a read issued in cycle k, the data register still holds its value from before the read.
- R5: Reads issued in two consecutive cycles k and k+1 deliver their words in cycles k+2 and k+3, in issue order.
- R6: A write in cycle k presents the data register contents of cycle k as write data, at the scaled address, with the write strobe high. The memory word then reads back as that value.
- R7: A fetch in cycle k presents the program counter unchanged as the byte address. The fetch buffer keeps its previous value in cycle k+1 and holds the addressed byte from cycle k+2.
- R8: A fetch and a data read issued in the same cycle both complete in cycle k+2, each with its own result.
- R9: If read and write are requested in the same cycle, only the write reaches memory. The data register is not reloaded by a read result.
- R10: If a read result lands at the same edge as a data-register load from the result bus, the read result wins.
- R11: Loads from the result bus are visible in the next cycle. The word-address register takes the low AW-2 bits, the program counter the low AW bits, and the data register all DW bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cbus_in | input | DW | Datapath result bus feeding the three loadable registers |
| mar_we | input | 1 | Load word-address register from cbus_in |
| mdr_we | input | 1 | Load data register from cbus_in |
| pc_we | input | 1 | Load program counter from cbus_in |
| rd_req | input | 1 | Data read strobe for this cycle |
| wr_req | input | 1 | Data write strobe for this cycle |
| fetch_req | input | 1 | Instruction byte fetch strobe for this cycle |
| mar_q | output | AW-2 | Word-address register |
| mdr_q | output | DW | Data register |
| pc_q | output | AW | Program counter (byte address) |
| mbr_q | output | 8 | Fetch buffer |
| dmem_addr | output | AW | Data-port byte address to memory |
| dmem_rd | output | 1 | Data-port read enable to memory |
| dmem_wr | output | 1 | Data-port write enable to memory |
| dmem_wdata | output | DW | Data-port write data to memory |
| dmem_rdata | input | DW | Data-port read data, valid the cycle after the read |
| imem_addr | output | AW | Fetch-port byte address to memory |
| imem_rd | output | 1 | Fetch-port read enable to memory |
| imem_rdata | input | 8 | Fetch-port read byte, valid the cycle after the fetch |

## Verification
Memory-side strobes, address and write data are combinational in the issuing cycle. The bench therefore checks them shortly after it changes the inputs, before that cycle's edge. The data register and fetch buffer are checked twice per request. The first check is one cycle after issue, where the old value is still due. The second is two cycles after issue, where the new value is due. Every register check happens on the falling edge, half a cycle after the edge that could change it. A shadow copy of memory is kept from the bench's own writes, so every expected word and byte is computed from the initial fill formula plus those writes.

// File: rtl/mp_pkg.sv
package mp_pkg;

    localparam int WORD_SHIFT = 2;
    localparam int BYTE_W     = 8;

    typedef enum logic [1:0] {
        DOP_IDLE  = 2'd0,
        DOP_READ  = 2'd1,
        DOP_WRITE = 2'd2
    } dop_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic fetch;
    } req_t;

    // write has precedence over read; reset suppresses everything
    function automatic dop_e decode_dop(input req_t r, input logic in_reset);
        if (in_reset)  return DOP_IDLE;
        if (r.wr)      return DOP_WRITE;
        if (r.rd)      return DOP_READ;
        return DOP_IDLE;
    endfunction

endpackage

// File: rtl/mp_addr_regs.sv
module mp_addr_regs #(
    parameter int DW = 32,
    parameter int AW = 8,
    parameter int WAW = AW - 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [DW-1:0]  cbus_in,
    input  logic           mar_we,
    input  logic           pc_we,
    output logic [WAW-1:0] mar_q,
    output logic [AW-1:0]  pc_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mar_q <= '0;
            pc_q  <= '0;
        end else begin
            if (mar_we) mar_q <= cbus_in[WAW-1:0];
            if (pc_we)  pc_q  <= cbus_in[AW-1:0];
        end
    end

endmodule

// File: rtl/mp_track_pipe.sv
module mp_track_pipe #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic issue,
    output logic land
);

    logic [STAGES-1:0] stage_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= 1'b0;
                    else     stage_q[0] <= issue;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= 1'b0;
                    else     stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign land = stage_q[STAGES-1];

endmodule

// File: rtl/mp_dest_reg.sv
module mp_dest_reg #(
    parameter int W = 32,
    parameter bit HAS_LOCAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         land,
    input  logic [W-1:0] land_data,
    input  logic         local_we,
    input  logic [W-1:0] local_data,
    output logic [W-1:0] q
);

    logic         take_local;
    logic [W-1:0] nxt;

    generate
        if (HAS_LOCAL) begin : g_local
            assign take_local = local_we;
        end else begin : g_nolocal
            assign take_local = 1'b0;
        end
    endgenerate

    // memory result has priority over the datapath load
    always_comb begin
        nxt = q;
        if (land)            nxt = land_data;
        else if (take_local) nxt = local_data;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

endmodule

// File: rtl/wb_mem_port.sv
module wb_mem_port
    import mp_pkg::*;
#(
    parameter int DW      = 32,
    parameter int AW      = 8,
    parameter int MEM_LAT = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [DW-1:0]            cbus_in,
    input  logic                     mar_we,
    input  logic                     mdr_we,
    input  logic                     pc_we,
    input  logic                     rd_req,
    input  logic                     wr_req,
    input  logic                     fetch_req,
    output logic [AW-WORD_SHIFT-1:0] mar_q,
    output logic [DW-1:0]            mdr_q,
    output logic [AW-1:0]            pc_q,
    output logic [BYTE_W-1:0]        mbr_q,
    output logic [AW-1:0]            dmem_addr,
    output logic                     dmem_rd,
    output logic                     dmem_wr,
    output logic [DW-1:0]            dmem_wdata,
    input  logic [DW-1:0]            dmem_rdata,
    output logic [AW-1:0]            imem_addr,
    output logic                     imem_rd,
    input  logic [BYTE_W-1:0]        imem_rdata
);

    localparam int WAW = AW - WORD_SHIFT;

    req_t req;
    dop_e dop;
    logic d_land;
    logic i_land;

    assign req.rd    = rd_req;
    assign req.wr    = wr_req;
    assign req.fetch = fetch_req;
    assign dop       = decode_dop(req, rst);

    mp_addr_regs #(.DW(DW), .AW(AW), .WAW(WAW)) u_addr (
        .clk    (clk),
        .rst    (rst),
        .cbus_in(cbus_in),
        .mar_we (mar_we),
        .pc_we  (pc_we),
        .mar_q  (mar_q),
        .pc_q   (pc_q)
    );

    // data port request, combinational in the issuing cycle
    assign dmem_rd    = (dop == DOP_READ);
    assign dmem_wr    = (dop == DOP_WRITE);
    assign dmem_addr  = {mar_q, {WORD_SHIFT{1'b0}}};
    assign dmem_wdata = mdr_q;

    // fetch port request
    assign imem_rd   = req.fetch & ~rst;
    assign imem_addr = pc_q;

    mp_track_pipe #(.STAGES(MEM_LAT)) u_dtrk (
        .clk  (clk),
        .rst  (rst),
        .issue(dmem_rd),
        .land (d_land)
    );

    mp_track_pipe #(.STAGES(MEM_LAT)) u_itrk (
        .clk  (clk),
        .rst  (rst),
        .issue(imem_rd),
        .land (i_land)
    );

    mp_dest_reg #(.W(DW), .HAS_LOCAL(1'b1)) u_mdr (
        .clk       (clk),
        .rst       (rst),
        .land      (d_land),
        .land_data (dmem_rdata),
        .local_we  (mdr_we),
        .local_data(cbus_in),
        .q         (mdr_q)
    );

    mp_dest_reg #(.W(BYTE_W), .HAS_LOCAL(1'b0)) u_mbr (
        .clk       (clk),
        .rst       (rst),
        .land      (i_land),
        .land_data (imem_rdata),
        .local_we  (1'b0),
        .local_data('0),
        .q         (mbr_q)
    );

endmodule

// File: rtl/wb_mem_port_chk.sv
module wb_mem_port_chk #(
    parameter int DW      = 32,
    parameter int AW      = 8,
    parameter int MEM_LAT = 1
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_req,
    input logic          wr_req,
    input logic          mdr_we,
    input logic [AW-3:0] mar_q,
    input logic [DW-1:0] mdr_q,
    input logic [7:0]    mbr_q,
    input logic [AW-1:0] dmem_addr,
    input logic          dmem_rd,
    input logic          dmem_wr,
    input logic [DW-1:0] dmem_rdata,
    input logic          imem_rd,
    input logic [7:0]    imem_rdata,
    input logic          d_land,
    input logic          i_land
);

    p_quiet_in_reset_r1: assert property (@(posedge clk)
        rst |-> (!dmem_rd && !dmem_wr && !imem_rd));

    p_addr_scale_r2: assert property (@(posedge clk) disable iff (rst)
        (dmem_rd || dmem_wr) |-> (dmem_addr[1:0] == 2'b00 && dmem_addr[AW-1:2] == mar_q));

    p_mdr_lands_r3: assert property (@(posedge clk) disable iff (rst)
        d_land |=> (mdr_q == $past(dmem_rdata)));

    p_mdr_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (!d_land && !mdr_we) |=> $stable(mdr_q));

    generate
        if (MEM_LAT == 1) begin : g_lat1
            p_issue_to_land_r5: assert property (@(posedge clk) disable iff (rst)
                dmem_rd |=> d_land);
            p_fetch_to_land_r7: assert property (@(posedge clk) disable iff (rst)
                imem_rd |=> i_land);
        end
    endgenerate

    p_mbr_lands_r7: assert property (@(posedge clk) disable iff (rst)
        i_land |=> (mbr_q == $past(imem_rdata)));

    p_mbr_holds_r7: assert property (@(posedge clk) disable iff (rst)
        !i_land |=> $stable(mbr_q));

    p_write_only_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_req && wr_req) |-> (dmem_wr && !dmem_rd));

    p_land_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (d_land && mdr_we) |=> (mdr_q == $past(dmem_rdata)));

endmodule

bind wb_mem_port wb_mem_port_chk #(.DW(DW), .AW(AW), .MEM_LAT(MEM_LAT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .mdr_we    (mdr_we),
    .mar_q     (mar_q),
    .mdr_q     (mdr_q),
    .mbr_q     (mbr_q),
    .dmem_addr (dmem_addr),
    .dmem_rd   (dmem_rd),
    .dmem_wr   (dmem_wr),
    .dmem_rdata(dmem_rdata),
    .imem_rd   (imem_rd),
    .imem_rdata(imem_rdata),
    .d_land    (d_land),
    .i_land    (i_land)
);

// File: tb/wb_mem_port_tb.sv
module wb_mem_port_tb;

    localparam int DW  = 32;
    localparam int AW  = 8;
    localparam int WAW = AW - 2;
    localparam int NB  = 1 << AW;
    localparam int NW  = 1 << WAW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [DW-1:0]  cbus_in = '0;
    logic           mar_we = 0, mdr_we = 0, pc_we = 0;
    logic           rd_req = 0, wr_req = 0, fetch_req = 0;
    logic [WAW-1:0] mar_q;
    logic [DW-1:0]  mdr_q;
    logic [AW-1:0]  pc_q;
    logic [7:0]     mbr_q;
    logic [AW-1:0]  dmem_addr;
    logic           dmem_rd, dmem_wr;
    logic [DW-1:0]  dmem_wdata;
    logic [DW-1:0]  dmem_rdata = '0;
    logic [AW-1:0]  imem_addr;
    logic           imem_rd;
    logic [7:0]     imem_rdata = '0;

    logic [7:0] mem    [NB];
    logic [7:0] shadow [NB];

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #4 clk = ~clk;

    wb_mem_port #(.DW(DW), .AW(AW), .MEM_LAT(1)) u_dut (
        .clk(clk), .rst(rst), .cbus_in(cbus_in),
        .mar_we(mar_we), .mdr_we(mdr_we), .pc_we(pc_we),
        .rd_req(rd_req), .wr_req(wr_req), .fetch_req(fetch_req),
        .mar_q(mar_q), .mdr_q(mdr_q), .pc_q(pc_q), .mbr_q(mbr_q),
        .dmem_addr(dmem_addr), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .imem_addr(imem_addr), .imem_rd(imem_rd), .imem_rdata(imem_rdata)
    );

    // behavioural synchronous memory, one-cycle read, read-before-write
    always @(posedge clk) begin
        if (dmem_rd)
            dmem_rdata <= {mem[int'(dmem_addr) + 3], mem[int'(dmem_addr) + 2],
                           mem[int'(dmem_addr) + 1], mem[int'(dmem_addr)]};
        if (imem_rd)
            imem_rdata <= mem[int'(imem_addr)];
        if (dmem_wr) begin
            mem[int'(dmem_addr)]     <= dmem_wdata[7:0];
            mem[int'(dmem_addr) + 1] <= dmem_wdata[15:8];
            mem[int'(dmem_addr) + 2] <= dmem_wdata[23:16];
            mem[int'(dmem_addr) + 3] <= dmem_wdata[31:24];
        end
    end

    function automatic logic [7:0] fill_byte(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    function automatic logic [31:0] exp_word(input int w);
        return {shadow[4*w+3], shadow[4*w+2], shadow[4*w+1], shadow[4*w]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic load_mar(input int w);
        cbus_in = {26'h2AAAAAA, 6'(w)};
        mar_we  = 1;
        step();
        mar_we  = 0;
        chk("R11 mar load", 32'(mar_q), 32'(w));
    endtask

    task automatic load_mdr(input logic [31:0] d);
        cbus_in = d;
        mdr_we  = 1;
        step();
        mdr_we  = 0;
        chk("R11 mdr load", mdr_q, d);
    endtask

    task automatic read_word(input int w);
        logic [31:0] old;
        load_mar(w);
        old    = mdr_q;
        rd_req = 1;
        #1;
        chk("R2 read addr", 32'(dmem_addr), 32'(4 * w));
        chk("R2 read strobe", 32'(dmem_rd), 32'd1);
        step();
        rd_req = 0;
        chk("R4 old data held", mdr_q, old);
        step();
        chk("R3 read result", mdr_q, exp_word(w));
    endtask

    task automatic fetch_byte(input int p);
        logic [7:0] old;
        cbus_in = {24'h5A5A5A, 8'(p)};
        pc_we   = 1;
        step();
        pc_we   = 0;
        chk("R11 pc load", 32'(pc_q), 32'(p));
        old       = mbr_q;
        fetch_req = 1;
        #1;
        chk("R7 fetch addr", 32'(imem_addr), 32'(p));
        step();
        fetch_req = 0;
        chk("R7 fetch buffer held", 32'(mbr_q), 32'(old));
        step();
        chk("R7 fetch result", 32'(mbr_q), 32'(shadow[p]));
    endtask

    task automatic write_word(input int w, input logic [31:0] d);
        load_mar(w);
        load_mdr(d);
        wr_req = 1;
        #1;
        chk("R6 write strobe", 32'(dmem_wr), 32'd1);
        chk("R6 write addr", 32'(dmem_addr), 32'(4 * w));
        chk("R6 write data", dmem_wdata, d);
        step();
        wr_req = 0;
        for (int b = 0; b < 4; b++) shadow[4*w+b] = d[8*b +: 8];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) begin
            mem[i]    = fill_byte(i);
            shadow[i] = fill_byte(i);
        end

        // R1: strobes quiet during reset, registers clear
        rd_req = 1; wr_req = 0; fetch_req = 1;
        step(); step();
        #1;
        chk("R1 no read in reset", 32'(dmem_rd), 32'd0);
        chk("R1 no fetch in reset", 32'(imem_rd), 32'd0);
        wr_req = 1;
        #1;
        chk("R1 no write in reset", 32'(dmem_wr), 32'd0);
        step();
        rd_req = 0; wr_req = 0; fetch_req = 0;
        rst = 0;
        chk("R1 mar reset", 32'(mar_q), 32'd0);
        chk("R1 mdr reset", mdr_q, 32'd0);
        chk("R1 pc reset", 32'(pc_q), 32'd0);
        chk("R1 mbr reset", 32'(mbr_q), 32'd0);
        step();

        // R2 R3 R4: every word index
        for (int w = 0; w < NW; w++) read_word(w);

        // R7: every byte address
        for (int p = 0; p < NB; p++) fetch_byte(p);

        // R5: back-to-back reads, MAR reloaded in the first issue cycle
        begin
            logic [31:0] old;
            load_mar(9);
            old     = mdr_q;
            rd_req  = 1;
            cbus_in = 32'd41;
            mar_we  = 1;
            #1;
            chk("R2 issue-cycle address", 32'(dmem_addr), 32'(4 * 9));
            step();
            mar_we = 0;
            #1;
            chk("R5 second addr", 32'(dmem_addr), 32'(4 * 41));
            step();
            rd_req = 0;
            chk("R5 first result", mdr_q, exp_word(9));
            step();
            chk("R5 second result", mdr_q, exp_word(41));
        end

        // R6: writes then read back
        for (int w = 0; w < NW; w += 7) begin
            write_word(w, 32'hC0DE_0000 ^ 32'(w * 32'h01010101));
            read_word(w);
        end

        // R8: fetch and data read in the same cycle
        begin
            cbus_in = 32'd200; pc_we = 1;
            step();
            pc_we = 0;
            load_mar(50);
            rd_req = 1; fetch_req = 1;
            step();
            rd_req = 0; fetch_req = 0;
            step();
            chk("R8 data result", mdr_q, exp_word(50));
            chk("R8 fetch result", 32'(mbr_q), 32'(shadow[200]));
        end

        // R9: read and write together, only the write happens
        begin
            load_mar(12);
            load_mdr(32'hFEED_BEEF);
            rd_req = 1; wr_req = 1;
            #1;
            chk("R9 no read strobe", 32'(dmem_rd), 32'd0);
            chk("R9 write strobe", 32'(dmem_wr), 32'd1);
            step();
            rd_req = 0; wr_req = 0;
            for (int b = 0; b < 4; b++) shadow[48+b] = 8'(32'hFEED_BEEF >> (8*b));
            step();
            chk("R9 mdr not reloaded", mdr_q, 32'hFEED_BEEF);
            step();
            chk("R9 mdr still", mdr_q, 32'hFEED_BEEF);
            read_word(12);
        end

        // R10: read result beats result-bus load at the same edge
        begin
            load_mar(33);
            rd_req = 1;
            step();
            rd_req  = 0;
            cbus_in = 32'h1234_5678;
            mdr_we  = 1;
            step();
            mdr_we = 0;
            chk("R10 result wins", mdr_q, exp_word(33));
        end

        step();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule